// File: doc/BRIEF.md
# Processor Port with Address Map Steering

This block is an eight-line bidirectional I/O port that lives at the two lowest addresses of a 16-bit processor address space. Address 0x0000 holds the direction register and address 0x0001 holds the data register. The value seen on the port lines decides which device answers in three upper address windows. The block therefore sits between the processor bus and the memory devices. Software can flip a ROM out of the map, and a RAM image shows up at the same addresses.

Each bus cycle, the block takes the address and produces one registered select: the port itself, ROM A, ROM B, the peripheral window, or RAM. A read of either port address returns registered data one cycle after the address. A pin set as an output reads back its latched value. A pin set as an input reads back its live level. Bank control uses the same mix, so a bank line set as an input is steered by whatever drives the pin, such as an external pull-up.

Top module: `cpu_port_bank`

## Requirements
- R1: A synchronous active-high reset clears the direction register (all pins inputs, `pin_oe`=0x00) and the data register (`pin_out`=0x00). It also forces `cpu_rdata` to 0x00 and every select output low.
- R2: A write (`cpu_we`=1) to 0x0000 loads the direction register. A 1 bit makes that pin an output and shows on `pin_oe` from the next cycle. A read of 0x0000 returns the register.
- R3: A write to 0x0001 loads the data register, which drives `pin_out` in full from the next cycle.
- R4: A read of 0x0001 returns, per bit, the data register where the direction bit is 1 and the live `pin_in` level where it is 0. This covers bit 4 used as a switch sense input.
- R5: Any access, read or write, to 0x0000 or 0x0001 asserts `sel_port` and no memory select. In particular it never asserts `cs_ram`.
- R6: Addresses 0xA000–0xBFFF select ROM A when steering bit 0 is 1, and RAM when it is 0.
- R7: Addresses 0xE000–0xFFFF select ROM B when steering bit 1 is 1, and RAM when it is 0.
- R8: Addresses 0xD000–0xDFFF select the I/O window when steering bit 0 or bit 1 is 1. When both are 0 they select RAM.
- R9: Every other address selects RAM. In every cycle after reset, exactly one of the five select outputs is high.
- R10: Each steering bit is the data register bit when its pin is an output, and the `pin_in` level when it is an input.
- R11: Selects and read data are registered. They appear in the cycle after the address, and a write to a port register steers the very next access.
- R12: `cpu_rdata` is 0x00 on write cycles and for addresses outside the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| pin_in | input | 8 | Live level on the port lines |
| cpu_rdata | output | 8 | Registered port read data |
| pin_out | output | 8 | Port output values (data register) |
| pin_oe | output | 8 | Per-line output enable (direction register) |
| sel_port | output | 1 | Access hit a port register |
| cs_rom_a | output | 1 | ROM A select |
| cs_rom_b | output | 1 | ROM B select |
| cs_io | output | 1 | I/O window select |
| cs_ram | output | 1 | RAM select |

## Verification
Some rules are checked on every clock by the assertions:
- exactly one select is high;
- a port address never reaches RAM;
- ROM A, ROM B and the I/O window only appear when their steering bits were set in the cycle before;
- writes land in the direction and data registers.

Other behaviour only the bench scenarios can show:
- the per-bit readback mix of latched and live values;
- RAM taking over each window as the bank bits fall;
- pins used as inputs steering the map;
- a reset in the middle of a run.

// File: rtl/cpu_port_bank_pkg.sv
package cpu_port_bank_pkg;
  typedef enum logic [2:0] {
    RGN_RAM,
    RGN_ROM_A,
    RGN_ROM_B,
    RGN_IO,
    RGN_PORT
  } region_e;
endpackage

// File: rtl/cpu_port_regs.sv
module cpu_port_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = '0,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] line_level
);
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] rdata_q;

  // per-line mix: driven lines show the latch, input lines show the pad
  for (genvar b = 0; b < DATA_W; b++) begin : g_line
    assign line_level[b] = dir_q[b] ? dat_q[b] : pin_in[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (we) begin
      if (addr == DIR_ADDR) dir_q <= wdata;
      if (addr == DAT_ADDR) dat_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (!we && addr == DIR_ADDR) begin
      rdata_q <= dir_q;
    end else if (!we && addr == DAT_ADDR) begin
      rdata_q <= line_level;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata   = rdata_q;
  assign pin_out = dat_q;
  assign pin_oe  = dir_q;

  AST_REGS_RESET: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && dat_q == '0 && rdata_q == '0)); // R1
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(addr) == DIR_ADDR) |-> dir_q == $past(wdata)); // R2
  AST_DAT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(addr) == DAT_ADDR) |-> dat_q == $past(wdata)); // R3
endmodule

// File: rtl/cpu_port_decode.sv
module cpu_port_decode
  import cpu_port_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = '0,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 1,
  parameter logic [ADDR_W-1:0] ROMA_BASE = 16'hA000,
  parameter logic [ADDR_W-1:0] ROMA_MASK = 16'hE000,
  parameter logic [ADDR_W-1:0] ROMB_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] ROMB_MASK = 16'hE000,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hD000,
  parameter logic [ADDR_W-1:0] IO_MASK   = 16'hF000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_a,
  input  logic              bank_b,
  output logic              sel_port,
  output logic              cs_rom_a,
  output logic              cs_rom_b,
  output logic              cs_io,
  output logic              cs_ram
);
  region_e rgn;
  logic    in_port, in_roma, in_romb, in_io;

  assign in_port = (addr == DIR_ADDR) || (addr == DAT_ADDR);
  assign in_roma = (addr & ROMA_MASK) == ROMA_BASE;
  assign in_romb = (addr & ROMB_MASK) == ROMB_BASE;
  assign in_io   = (addr & IO_MASK) == IO_BASE;

  always_comb begin
    rgn = RGN_RAM;
    if (in_port)                       rgn = RGN_PORT;
    else if (in_roma && bank_a)        rgn = RGN_ROM_A;
    else if (in_romb && bank_b)        rgn = RGN_ROM_B;
    else if (in_io && (bank_a || bank_b)) rgn = RGN_IO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_port <= 1'b0;
      cs_rom_a <= 1'b0;
      cs_rom_b <= 1'b0;
      cs_io    <= 1'b0;
      cs_ram   <= 1'b0;
    end else begin
      sel_port <= (rgn == RGN_PORT);
      cs_rom_a <= (rgn == RGN_ROM_A);
      cs_rom_b <= (rgn == RGN_ROM_B);
      cs_io    <= (rgn == RGN_IO);
      cs_ram   <= (rgn == RGN_RAM);
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot({sel_port, cs_rom_a, cs_rom_b, cs_io, cs_ram})); // R9
  AST_PORT_NOT_RAM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(addr) == DIR_ADDR || $past(addr) == DAT_ADDR)) |-> (sel_port && !cs_ram)); // R5
  AST_ROMA_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_rom_a |-> $past(bank_a)); // R6
  AST_ROMB_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_rom_b |-> $past(bank_b)); // R7
  AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_io |-> ($past(bank_a) || $past(bank_b))); // R8
endmodule

// File: rtl/cpu_port_bank.sv
module cpu_port_bank #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_A_BIT = 0,
  parameter int BANK_B_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              sel_port,
  output logic              cs_rom_a,
  output logic              cs_rom_b,
  output logic              cs_io,
  output logic              cs_ram
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = '0;
  localparam logic [ADDR_W-1:0] DAT_ADDR = DIR_ADDR + 1'b1;

  logic [DATA_W-1:0] line_level;

  cpu_port_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(cpu_addr), .wdata(cpu_wdata), .we(cpu_we),
    .pin_in(pin_in), .rdata(cpu_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .line_level(line_level)
  );

  cpu_port_decode #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
  ) decode_i (
    .clk(clk), .rst(rst), .addr(cpu_addr),
    .bank_a(line_level[BANK_A_BIT]), .bank_b(line_level[BANK_B_BIT]),
    .sel_port(sel_port), .cs_rom_a(cs_rom_a), .cs_rom_b(cs_rom_b),
    .cs_io(cs_io), .cs_ram(cs_ram)
  );
endmodule

// File: tb/cpu_port_bank_tb_top.sv
`timescale 1ns/1ps
module cpu_port_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  cpu_rdata, pin_out, pin_oe;
  logic        sel_port, cs_rom_a, cs_rom_b, cs_io, cs_ram;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cpu_port_bank dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .pin_in(pin_in), .cpu_rdata(cpu_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .sel_port(sel_port), .cs_rom_a(cs_rom_a),
    .cs_rom_b(cs_rom_b), .cs_io(cs_io), .cs_ram(cs_ram)
  );

  // select code {port, romA, romB, io, ram}
  localparam logic [4:0] S_PORT = 5'b10000, S_ROMA = 5'b01000, S_ROMB = 5'b00100,
                         S_IO = 5'b00010, S_RAM = 5'b00001;
  // {addr, we, wdata, pins, expected rdata, expected select}
  localparam int NV = 29;
  localparam logic [45:0] VEC [NV] = '{
    {16'hA000, 1'b0, 8'h00, 8'hFF, 8'h00, S_ROMA}, // R6 R10 pull-ups
    {16'hE123, 1'b0, 8'h00, 8'hFF, 8'h00, S_ROMB}, // R7
    {16'hD400, 1'b0, 8'h00, 8'hFF, 8'h00, S_IO},   // R8
    {16'h1234, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R9 R12
    {16'h0000, 1'b0, 8'h00, 8'hFF, 8'h00, S_PORT}, // R2 R5
    {16'h0001, 1'b0, 8'h00, 8'hEF, 8'hEF, S_PORT}, // R4 switch bit 4 low
    {16'h0000, 1'b1, 8'h07, 8'hFF, 8'h00, S_PORT}, // R5 R12 write
    {16'h0001, 1'b1, 8'h06, 8'hFF, 8'h00, S_PORT}, // R5 write
    {16'h0000, 1'b0, 8'h00, 8'hFF, 8'h07, S_PORT}, // R2
    {16'h0001, 1'b0, 8'h00, 8'hFF, 8'hFE, S_PORT}, // R4
    {16'h0001, 1'b0, 8'h00, 8'hE0, 8'hE6, S_PORT}, // R4
    {16'hA000, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R6 bit0 driven 0
    {16'hBFFF, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R6
    {16'hE000, 1'b0, 8'h00, 8'hFF, 8'h00, S_ROMB}, // R7
    {16'hDFFF, 1'b0, 8'h00, 8'hFF, 8'h00, S_IO},   // R8 bit1 only
    {16'h0001, 1'b1, 8'h00, 8'hFF, 8'h00, S_PORT}, // R3
    {16'hD000, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R8 R11 both low
    {16'hFFFF, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R7
    {16'hCFFF, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R9
    {16'h0001, 1'b1, 8'h01, 8'hFF, 8'h00, S_PORT}, // R3
    {16'hA123, 1'b0, 8'h00, 8'hFF, 8'h00, S_ROMA}, // R6 R11 next access
    {16'hD800, 1'b0, 8'h00, 8'hFF, 8'h00, S_IO},   // R8 bit0 only
    {16'hE000, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R7
    {16'h0001, 1'b0, 8'h00, 8'h00, 8'h01, S_PORT}, // R4
    {16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, S_PORT}, // R2 all inputs
    {16'hA000, 1'b0, 8'h00, 8'h00, 8'h00, S_RAM},  // R10 pins low
    {16'hD000, 1'b0, 8'h00, 8'h02, 8'h00, S_IO},   // R10 pin bit1 high
    {16'h9FFF, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM},  // R9
    {16'h0002, 1'b0, 8'h00, 8'hFF, 8'h00, S_RAM}   // R9 R12 next to port
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [15:0] a, input logic w, input logic [7:0] d, input logic [7:0] p);
    cpu_addr = a; cpu_we = w; cpu_wdata = d; pin_in = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] sels();
    return {sel_port, cs_rom_a, cs_rom_b, cs_io, cs_ram};
  endfunction

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin_oe == 8'h00 && pin_out == 8'h00, "R1 pins", {pin_oe, pin_out}, 0);
    check(cpu_rdata == 8'h00 && sels() == 5'b0, "R1 rdata/selects", {cpu_rdata, 3'b0, sels()}, 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      cycle(v[45:30], v[29], v[28:21], v[20:13]);
      check(cpu_rdata == v[12:5], $sformatf("R4/R12 rdata vec%0d", i), cpu_rdata, v[12:5]);
      check(sels() == v[4:0], $sformatf("R5-R9 select vec%0d", i), sels(), v[4:0]);
    end
    // R2 R3: pins follow registers
    cycle(16'h0000, 1'b1, 8'hF0, 8'h0F);
    cycle(16'h0001, 1'b1, 8'hA5, 8'h0F);
    check(pin_oe == 8'hF0, "R2 pin_oe", pin_oe, 8'hF0);
    check(pin_out == 8'hA5, "R3 pin_out", pin_out, 8'hA5);
    cycle(16'h0001, 1'b0, 8'h00, 8'h0F);
    check(cpu_rdata == 8'hAF, "R4 mixed readback", cpu_rdata, 8'hAF);
    cycle(16'hE000, 1'b0, 8'h00, 8'h0F);
    check(sels() == S_ROMB, "R10 input bit1 high", sels(), S_ROMB);
    cycle(16'hE000, 1'b0, 8'h00, 8'h0D);
    check(sels() == S_RAM, "R10 input bit1 low", sels(), S_RAM);
    // R1 reset in mid run
    rst = 1'b1;
    cycle(16'h0001, 1'b0, 8'h00, 8'h5A);
    cycle(16'h0001, 1'b0, 8'h00, 8'h5A);
    check(pin_oe == 8'h00 && pin_out == 8'h00, "R1 mid-run pins", {pin_oe, pin_out}, 0);
    check(sels() == 5'b0 && cpu_rdata == 8'h00, "R1 mid-run outputs", {cpu_rdata, 3'b0, sels()}, 0);
    rst = 1'b0;
    cycle(16'h0001, 1'b0, 8'h00, 8'h5A);
    check(cpu_rdata == 8'h5A, "R4 after reset all inputs", cpu_rdata, 8'h5A);
    check(sels() == S_PORT, "R5 after reset", sels(), S_PORT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule